// File: doc/BRIEF.md
# Edge-Triggered Timer Capture Unit

This block records the moment an external event happens by freezing the value of a free-running 16-bit timer. A raw capture pin is first brought into the clock domain by a chain of flip-flops. The unit then looks for a transition of the polarity picked by a select input. When that transition arrives, the current timer count is stored in a capture register that software can only read, and a pending flag is raised.

Software reads the stored value over an 8-bit data path in two accesses. Reading the low half returns its byte and also moves the upper byte into a staging byte. The next upper-half read returns that staged byte. The two bytes therefore always belong to the same event, even if a new capture lands between the two reads. Writing a one to the flag-clear strobe acknowledges the event. A capture that arrives in the same cycle as a clear wins, and the flag stays raised.

Top module: `icap_unit`

## Requirements
- R1: After synchronous reset the capture register, the staging byte, `rd_data` and `cap_flag` are all zero, so a low read and then a high read each return 8'h00.
- R2: With `edge_rise` = 1 only a low-to-high transition of `cap_pin` triggers a capture, and a high-to-low transition leaves the stored value unchanged.
- R3: With `edge_rise` = 0 only a high-to-low transition of `cap_pin` triggers a capture, and a low-to-high transition neither stores a value nor raises the flag.
- R4: A new `cap_pin` level first sampled at clock edge N is captured at edge N+2. At that edge the register takes the `count` present at the edge, and `cap_flag` goes to 1 at the same edge.
- R5: A cycle with `rd_lo` = 1 puts bits [7:0] of the capture register on `rd_data` after that edge, and copies bits [15:8] into the staging byte.
- R6: A cycle with `rd_hi` = 1 (and `rd_lo` = 0) puts the staging byte on `rd_data`, not the current upper half of the capture register.
- R7: `flag_clr` = 1 clears `cap_flag` at the next edge, unless a capture happens at that same edge, in which case the flag stays 1.
- R8: Each new capture overwrites the register whether or not the previous value was read.
- R9: With neither read strobe active, `rd_data` holds its last value. When `rd_lo` and `rd_hi` are both 1, the low read takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Raw capture input, asynchronous to clk |
| edge_rise | input | 1 | 1 selects rising edges, 0 selects falling edges |
| count | input | 16 | Current timer count |
| rd_lo | input | 1 | Read strobe for the low byte |
| rd_hi | input | 1 | Read strobe for the high byte |
| flag_clr | input | 1 | Write-one-to-clear for the capture flag |
| rd_data | output | 8 | Registered read data |
| cap_flag | output | 1 | Capture pending flag |

## Verification
A pin change driven before edge N must not show a flag after edges N or N+1. It must show the stored count after edge N+2, and the bench checks every one of those edges. Read data is due one edge after its strobe, and a clear takes effect at the strobe's own edge. The driver pushes one expected item per clock edge into a queue. The monitor compares that item with the outputs 5 ns after the edge, when every register on the path has settled. Counts are held steady around each capture edge, so the expected value is known without looking inside the design.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;

  function automatic logic edge_hit(input edge_sel_e sel, input logic now_s, input logic old_s);
    if (sel == EDGE_RISE) return now_s & ~old_s;
    else                  return ~now_s & old_s;
  endfunction
endpackage

// File: rtl/icap_edge.sv
module icap_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  input  logic rise_sel,
  output logic hit
);
  import icap_pkg::*;

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= pin_in;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[LAST];
  end

  always_comb begin
    hit = edge_hit(edge_sel_e'(rise_sel), sync_q[LAST], prev_q);
  end
endmodule

// File: rtl/icap_hold.sv
module icap_hold #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [CNT_W-1:0] count,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap_q,
  output logic             flag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (hit) cap_q <= count;
      if (hit)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/icap_rdport.sv
module icap_rdport #(
  parameter int unsigned BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_lo,
  input  logic               rd_hi,
  input  logic [2*BUS_W-1:0] cap_in,
  output logic [BUS_W-1:0]   rd_data
);
  logic [BUS_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      rd_data <= '0;
    end else if (rd_lo) begin
      rd_data <= cap_in[BUS_W-1:0];
      stage_q <= cap_in[2*BUS_W-1:BUS_W];
    end else if (rd_hi) begin
      rd_data <= stage_q;
    end
  end
endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
  parameter int unsigned BUS_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap_pin,
  input  logic                 edge_rise,
  input  logic [2*BUS_W-1:0]   count,
  input  logic                 rd_lo,
  input  logic                 rd_hi,
  input  logic                 flag_clr,
  output logic [BUS_W-1:0]     rd_data,
  output logic                 cap_flag
);
  localparam int unsigned CNT_W = 2 * BUS_W;

  logic             cap_ev;
  logic [CNT_W-1:0] cap_val;

  icap_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin_in(cap_pin), .rise_sel(edge_rise), .hit(cap_ev)
  );

  icap_hold #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst(rst), .hit(cap_ev), .count(count), .flag_clr(flag_clr),
    .cap_q(cap_val), .flag_q(cap_flag)
  );

  icap_rdport #(.BUS_W(BUS_W)) u_rd (
    .clk(clk), .rst(rst), .rd_lo(rd_lo), .rd_hi(rd_hi), .cap_in(cap_val),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
  parameter int unsigned BUS_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               cap_ev,
  input logic [2*BUS_W-1:0] count,
  input logic [2*BUS_W-1:0] cap_val,
  input logic               cap_flag,
  input logic               flag_clr,
  input logic               rd_lo,
  input logic               rd_hi,
  input logic [BUS_W-1:0]   rd_data
);
  p_flag_on_capture_r4: assert property (@(posedge clk) disable iff (rst)
    cap_ev |=> cap_flag);

  p_value_on_capture_r4: assert property (@(posedge clk) disable iff (rst)
    cap_ev |=> cap_val == $past(count));

  p_clear_wins_alone_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !cap_ev) |=> !cap_flag);

  p_reg_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !cap_ev |=> $stable(cap_val));

  p_low_read_r5: assert property (@(posedge clk) disable iff (rst)
    rd_lo |=> rd_data == $past(cap_val[BUS_W-1:0]));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!rd_lo && !rd_hi) |=> $stable(rd_data));
endmodule

bind icap_unit icap_unit_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .cap_ev(cap_ev), .count(count), .cap_val(cap_val),
  .cap_flag(cap_flag), .flag_clr(flag_clr), .rd_lo(rd_lo), .rd_hi(rd_hi),
  .rd_data(rd_data)
);

// File: tb/test_icap_unit.sv
`timescale 1ns/1ps
module test_icap_unit;
  typedef struct {
    string      req;
    logic [7:0] d;
    logic       f;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_pin = 1'b0;
  logic        edge_rise = 1'b1;
  logic [15:0] count = 16'h1234;
  logic        rd_lo = 1'b0, rd_hi = 1'b0, flag_clr = 1'b0;
  logic [7:0]  rd_data;
  logic        cap_flag;

  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  icap_unit i_icap_unit (
    .clk(clk), .rst(rst), .cap_pin(cap_pin), .edge_rise(edge_rise), .count(count),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .flag_clr(flag_clr), .rd_data(rd_data),
    .cap_flag(cap_flag)
  );

  // driver: one call = one clock edge, one expected item
  task automatic cyc(input logic pin, input logic lo, input logic hi, input logic clr,
                     input string req, input logic [7:0] d, input logic f);
    exp_t e;
    @(negedge clk);
    cap_pin = pin; rd_lo = lo; rd_hi = hi; flag_clr = clr;
    @(posedge clk);
    #1;
    e.req = req; e.d = d; e.f = f;
    q.push_back(e);
  endtask

  // monitor: compares 5 ns after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (rd_data !== e.d || cap_flag !== e.f) begin
          n_bad++;
          $display("FAIL %s: rd_data=%h cap_flag=%b expected rd_data=%h cap_flag=%b",
                   e.req, rd_data, cap_flag, e.d, e.f);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    cyc(0,0,0,0,"R1",8'h00,0);
    cyc(0,1,0,0,"R1",8'h00,0);
    cyc(0,0,1,0,"R1",8'h00,0);
    // R2/R4 rising capture, latency of three edges
    count = 16'hA55A;
    cyc(1,0,0,0,"R4",8'h00,0);
    cyc(1,0,0,0,"R4",8'h00,0);
    cyc(1,0,0,0,"R2",8'h00,1);
    count = 16'h7777;
    cyc(1,1,0,0,"R5",8'h5A,1);
    cyc(1,0,1,0,"R5",8'hA5,1);
    // R2 falling ignored under rising select
    count = 16'h1111;
    for (int i = 0; i < 4; i++) cyc(0,0,0,0,"R2",8'hA5,1);
    cyc(0,1,0,0,"R2",8'h5A,1);
    cyc(0,0,0,1,"R7",8'h5A,0);
    cyc(0,0,0,0,"R9",8'h5A,0);
    // R3 falling select
    edge_rise = 1'b0;
    count = 16'hBEEF;
    for (int i = 0; i < 4; i++) cyc(1,0,0,0,"R3",8'h5A,0);
    cyc(0,0,0,0,"R3",8'h5A,0);
    cyc(0,0,0,0,"R3",8'h5A,0);
    cyc(0,0,0,0,"R3",8'h5A,1);
    cyc(0,1,0,0,"R5",8'hEF,1);
    // R6 new capture between low and high read
    count = 16'hC0DE;
    for (int i = 0; i < 3; i++) cyc(1,0,0,0,"R6",8'hEF,1);
    for (int i = 0; i < 3; i++) cyc(0,0,0,0,"R6",8'hEF,1);
    cyc(0,0,1,0,"R6",8'hBE,1);
    cyc(0,1,0,0,"R8",8'hDE,1);
    cyc(0,0,1,0,"R6",8'hC0,1);
    // R8 two captures without a read in between
    count = 16'h0102;
    for (int i = 0; i < 3; i++) cyc(1,0,0,0,"R8",8'hC0,1);
    for (int i = 0; i < 3; i++) cyc(0,0,0,0,"R8",8'hC0,1);
    count = 16'h0304;
    for (int i = 0; i < 3; i++) cyc(1,0,0,0,"R8",8'hC0,1);
    for (int i = 0; i < 3; i++) cyc(0,0,0,0,"R8",8'hC0,1);
    cyc(0,1,0,0,"R8",8'h04,1);
    cyc(0,0,1,0,"R8",8'h03,1);
    // R7 capture and clear at the same edge
    cyc(0,0,0,1,"R7",8'h03,0);
    count = 16'h5566;
    for (int i = 0; i < 3; i++) cyc(1,0,0,0,"R7",8'h03,0);
    cyc(0,0,0,0,"R7",8'h03,0);
    cyc(0,0,0,0,"R7",8'h03,0);
    cyc(0,0,0,1,"R7",8'h03,1);
    cyc(0,0,0,1,"R7",8'h03,0);
    // R9 both strobes: low wins, then hold
    cyc(0,1,1,0,"R9",8'h66,0);
    cyc(0,0,0,0,"R9",8'h66,0);
    @(posedge clk); #8;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule